// File: doc/BRIEF.md
# MII Single-Buffer Frame Receiver

This block takes a 4-bit MII receive stream and turns it into stored frames. Each nibble arrives with a data-valid qualifier. The block discards the preamble and the start delimiter. It writes every following byte into one local buffer. While the frame arrives it runs a CRC-32 over it, counts the bytes and checks the destination address against the station address.

When a frame passes every check, the buffer locks and the frame length is published. A receive-valid flag rises and a one-cycle done pulse is emitted. From then on all line traffic is ignored until software issues a re-arm pulse. Software reads the stored bytes through a byte-wide read port, then re-arms the block. The re-arm frees the buffer for the next frame. After reset the receiver stays idle until the first re-arm.

Top module: `mii_frame_rx`

## Requirements
- R1: A frame that passes all checks sets `rx_valid_o`, and `rx_done_o` pulses for exactly one cycle. Both take effect at the clock edge that first samples `mii_rx_dv_i` low after the frame. `rx_done_o` is never high in the cycle after it was high.
- R2: `rx_len_o` equals the number of bytes that followed the start delimiter minus the 4 trailing FCS bytes. This covers destination, source, length/type, data and padding. It holds steady while `rx_valid_o` is high.
- R3: The first byte after the start delimiter is stored at buffer address 0, and each later byte at the next address. Each byte is assembled with the first received nibble as bits 3:0. `rd_data_o` shows the byte at `rd_addr_i` combinationally.
- R4: While `rx_valid_o` is high, further frames change neither the buffer, `rx_len_o` nor `rx_valid_o`. A one-cycle `rearm_i` pulse clears `rx_valid_o` at the next edge.
- R5: A frame whose CRC-32 fails is dropped without setting `rx_valid_o`. The CRC uses the reflected polynomial 0xEDB88320 with initial value all-ones and a complemented FCS sent least significant byte first. A frame that ends on half a byte is also dropped this way.
- R6: A frame is dropped when its total byte count, FCS included, is below 64 or above BUF_BYTES+4. Exactly 64 and exactly BUF_BYTES+4 bytes are accepted.
- R7: A frame is accepted only when its first six bytes equal `station_addr_i`, or are all 0xFF. For the match, byte k is compared with `station_addr_i[8k+7:8k]`.
- R8: After reset, `rx_valid_o`, `rx_done_o` and `rx_len_o` are 0. No frame is accepted before the first `rearm_i` pulse.
- R9: A re-arm that arrives while `mii_rx_dv_i` is high causes the rest of that frame to be ignored. The next frame is received normally.
- R10: The receiver looks for a nibble 0x5 directly followed by a nibble 0xD. Any nibbles before that pair are discarded, whatever the length of the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock, one nibble per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mii_rxd_i | input | 4 | MII receive nibble |
| mii_rx_dv_i | input | 1 | Receive data valid |
| rearm_i | input | 1 | Start/re-arm pulse from software |
| station_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| rd_addr_i | input | $clog2(BUF_BYTES) | Buffer read address |
| rd_data_o | output | 8 | Buffer read data |
| rx_len_o | output | $clog2(BUF_BYTES+1) | Stored frame length in bytes |
| rx_valid_o | output | 1 | A frame is held in the buffer |
| rx_done_o | output | 1 | One-cycle pulse when a frame is accepted |

## Verification
The bench sends a second, different frame while the buffer is locked. A design that fails to freeze would overwrite the stored bytes or change the published length. It sends frames at the size limits: 63 bytes, 64 bytes, BUF_BYTES+4 bytes and BUF_BYTES+5 bytes. An off-by-one in the length window would accept a runt or reject a full-size frame. A re-arm pulse is placed in the middle of an incoming frame. A receiver that starts mid-stream would lock onto the frame's tail bytes or a false delimiter. Frames are also sent before the first arm, with a corrupted payload, to a foreign address and after junk nibbles with a one-nibble preamble. A wrong arm state, a missing CRC check, missing filtering or a rigid preamble counter would each show up as a wrong receive-valid flag.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_HUNT,
    ST_RECV,
    ST_SKIP,
    ST_HOLD
  } rx_state_e;

  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  // reflected CRC-32, one nibble, LSB first
  function automatic logic [31:0] crc_nibble(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c ^ {28'd0, d};
    for (int i = 0; i < 4; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
  import mii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic [3:0] nib_i,
  output logic       ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (clear_i) crc_q <= CRC_INIT;
    else if (en_i)    crc_q <= crc_nibble(crc_q, nib_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/mii_rx_buf.sv
module mii_rx_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/mii_rx_addr_match.sv
module mii_rx_addr_match #(
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             byte_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [47:0]      station_i,
  output logic             match_o
);
  logic [7:0] sta_b [8];
  logic       uni_miss_q, bc_miss_q;
  logic       in_hdr;

  for (genvar g = 0; g < 8; g++) begin : g_sta
    if (g < 6) begin : g_used
      assign sta_b[g] = station_i[8*g +: 8];
    end else begin : g_pad
      assign sta_b[g] = 8'h00;
    end
  end

  assign in_hdr = byte_en_i && (idx_i < IDX_W'(6));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uni_miss_q <= 1'b0;
      bc_miss_q  <= 1'b0;
    end else if (clear_i) begin
      uni_miss_q <= 1'b0;
      bc_miss_q  <= 1'b0;
    end else if (in_hdr) begin
      if (byte_i != sta_b[idx_i[2:0]]) uni_miss_q <= 1'b1;
      if (byte_i != 8'hFF)             bc_miss_q  <= 1'b1;
    end
  end

  assign match_o = !uni_miss_q || !bc_miss_q;
endmodule

// File: rtl/mii_frame_rx.sv
module mii_frame_rx
  import mii_rx_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int MIN_BYTES = 64,
  localparam int AW    = $clog2(BUF_BYTES),
  localparam int LEN_W = $clog2(BUF_BYTES + 1),
  localparam int CNT_MAX = BUF_BYTES + 5,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       mii_rxd_i,
  input  logic             mii_rx_dv_i,
  input  logic             rearm_i,
  input  logic [47:0]      station_addr_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [LEN_W-1:0] rx_len_o,
  output logic             rx_valid_o,
  output logic             rx_done_o
);
  rx_state_e        state_q, state_d;
  logic [3:0]       nib_lo_q;
  logic             phase_q;
  logic             prev5_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;

  logic in_recv, byte_stb, buf_we, crc_ok, addr_ok, frame_ok, accept;
  logic [7:0] byte_val;
  logic [CNT_W-1:0] len_full;

  assign in_recv  = (state_q == ST_RECV);
  assign byte_stb = in_recv && mii_rx_dv_i && phase_q;
  assign byte_val = {mii_rxd_i, nib_lo_q};
  assign buf_we   = byte_stb && (cnt_q < CNT_W'(BUF_BYTES));

  mii_rx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!in_recv),
    .en_i    (in_recv && mii_rx_dv_i),
    .nib_i   (mii_rxd_i),
    .ok_o    (crc_ok)
  );

  mii_rx_addr_match #(.IDX_W(CNT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!in_recv),
    .byte_en_i (byte_stb),
    .idx_i     (cnt_q),
    .byte_i    (byte_val),
    .station_i (station_addr_i),
    .match_o   (addr_ok)
  );

  mii_rx_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (cnt_q[AW-1:0]),
    .wdata_i (byte_val),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign frame_ok = !phase_q && crc_ok && addr_ok &&
                    (cnt_q >= CNT_W'(MIN_BYTES)) &&
                    (cnt_q <= CNT_W'(BUF_BYTES + 4));
  assign accept   = in_recv && !mii_rx_dv_i && frame_ok;
  assign len_full = cnt_q - CNT_W'(4);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF, ST_HOLD: if (rearm_i) state_d = mii_rx_dv_i ? ST_SKIP : ST_HUNT;
      ST_HUNT: if (mii_rx_dv_i && prev5_q && mii_rxd_i == 4'hD) state_d = ST_RECV;
      ST_RECV: if (!mii_rx_dv_i) state_d = frame_ok ? ST_HOLD : ST_HUNT;
      ST_SKIP: if (!mii_rx_dv_i) state_d = ST_HUNT;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      nib_lo_q <= '0;
      phase_q  <= 1'b0;
      prev5_q  <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= accept;
      prev5_q <= (state_q == ST_HUNT) && mii_rx_dv_i && (mii_rxd_i == 4'h5);
      if (accept) len_q <= len_full[LEN_W-1:0];
      if (in_recv && mii_rx_dv_i) begin
        phase_q <= !phase_q;
        if (!phase_q) nib_lo_q <= mii_rxd_i;
        if (phase_q && cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end else if (!in_recv) begin
        phase_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end

  assign rx_len_o   = len_q;
  assign rx_valid_o = (state_q == ST_HOLD);
  assign rx_done_o  = done_q;
endmodule

// File: rtl/mii_frame_rx_chk.sv
module mii_frame_rx_chk #(
  parameter int BUF_BYTES = 256,
  parameter int MIN_BYTES = 64,
  parameter int LEN_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mii_rx_dv_i,
  input logic             rearm_i,
  input logic             rx_valid_o,
  input logic             rx_done_o,
  input logic [LEN_W-1:0] rx_len_o
);
  AST_DONE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (rx_valid_o && $rose(rx_valid_o))); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o); // R1
  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rearm_i) |=> $stable(rx_len_o)); // R2
  AST_HOLD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rearm_i) |=> rx_valid_o); // R4
  AST_REARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rearm_i) |=> !rx_valid_o); // R4
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_len_o >= LEN_W'(MIN_BYTES - 4) && rx_len_o <= LEN_W'(BUF_BYTES))); // R6
endmodule

bind mii_frame_rx mii_frame_rx_chk #(
  .BUF_BYTES (BUF_BYTES),
  .MIN_BYTES (MIN_BYTES),
  .LEN_W     (LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mii_rx_dv_i (mii_rx_dv_i),
  .rearm_i     (rearm_i),
  .rx_valid_o  (rx_valid_o),
  .rx_done_o   (rx_done_o),
  .rx_len_o    (rx_len_o)
);

// File: tb/mii_frame_rx_test.sv
module mii_frame_rx_test;
  localparam int BUF = 256;
  localparam int AW = $clog2(BUF);
  localparam int LW = $clog2(BUF + 1);
  localparam logic [47:0] STA = 48'h665544332211;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    rxd = '0;
  logic          dv = 1'b0;
  logic          rearm = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [LW-1:0] len;
  logic          valid, done;

  int total = 0;
  int bad = 0;
  logic [7:0] fb [300];

  always #10 clk = ~clk;

  mii_frame_rx #(.BUF_BYTES(BUF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mii_rxd_i(rxd), .mii_rx_dv_i(dv),
    .rearm_i(rearm), .station_addr_i(STA), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rx_len_o(len), .rx_valid_o(valid), .rx_done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // dkind: 0 station, 1 broadcast, 2 foreign
  task automatic build(input int n, input int dkind, input int seed);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n - 4; i++) begin
      if (i < 6) fb[i] = (dkind == 1) ? 8'hFF : (STA[8*i +: 8] ^ ((dkind == 2 && i == 0) ? 8'h01 : 8'h00));
      else       fb[i] = 8'((i * 7 + seed) & 255);
      c = c ^ {24'd0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fb[n - 4 + k] = c[8*k +: 8];
  endtask

  task automatic drive(input logic [3:0] n, input bit ra);
    @(posedge clk); #1;
    dv = 1'b1; rxd = n; rearm = ra;
  endtask

  task automatic send(input int n, input int pre, input bit junk, input int rearm_at);
    if (junk) begin drive(4'hA, 1'b0); drive(4'h3, 1'b0); end
    for (int p = 0; p < pre; p++) drive(4'h5, 1'b0);
    drive(4'hD, 1'b0);
    for (int i = 0; i < n; i++) begin
      drive(fb[i][3:0], (2 * i) == rearm_at);
      drive(fb[i][7:4], (2 * i + 1) == rearm_at);
    end
    @(posedge clk); #1;
    dv = 1'b0; rearm = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_rearm();
    @(posedge clk); #1 rearm = 1'b1;
    @(posedge clk); #1 rearm = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmp_buf(input int n, input string req);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i);
      #1;
      if (rd_data !== fb[i]) miss++;
    end
    check(miss == 0, req, miss, 0);
  endtask

  task automatic t_reset();
    check(valid == 0 && done == 0 && len == 0, "R8 reset", int'(valid) + int'(done) + int'(len), 0);
    build(64, 0, 1);
    send(64, 15, 0, -1);
    check(valid == 0, "R8 unarmed", valid, 0);
  endtask

  task automatic t_basic();
    do_rearm();
    build(64, 0, 3);
    send(64, 15, 0, -1);
    check(valid == 1, "R1 valid", valid, 1);
    check(done == 1, "R1 done pulse", done, 1);
    check(len == 60, "R2 length", int'(len), 60);
    cmp_buf(60, "R3 buffer bytes");
    @(negedge clk);
    check(done == 0, "R1 done one cycle", done, 0);
  endtask

  task automatic t_hold();
    logic [7:0] keep [60];
    for (int i = 0; i < 60; i++) keep[i] = fb[i];
    build(80, 0, 9);
    send(80, 15, 0, -1);
    check(valid == 1 && done == 0, "R4 still held", int'(valid) * 2 + int'(done), 2);
    check(len == 60, "R4 length frozen", int'(len), 60);
    for (int i = 0; i < 60; i++) fb[i] = keep[i];
    cmp_buf(60, "R4 buffer frozen");
    do_rearm();
    check(valid == 0, "R4 rearm clears", valid, 0);
  endtask

  task automatic t_crc();
    build(70, 0, 5);
    fb[20] = fb[20] ^ 8'h10;
    send(70, 15, 0, -1);
    check(valid == 0, "R5 bad crc", valid, 0);
  endtask

  task automatic t_len();
    build(63, 0, 2);
    send(63, 15, 0, -1);
    check(valid == 0, "R6 runt", valid, 0);
    build(BUF + 5, 0, 4);
    send(BUF + 5, 15, 0, -1);
    check(valid == 0, "R6 oversize", valid, 0);
    build(BUF + 4, 0, 6);
    send(BUF + 4, 15, 0, -1);
    check(valid == 1 && int'(len) == BUF, "R6 max size", int'(len), BUF);
    do_rearm();
  endtask

  task automatic t_addr();
    build(64, 2, 8);
    send(64, 15, 0, -1);
    check(valid == 0, "R7 foreign dest", valid, 0);
    build(66, 1, 8);
    send(66, 15, 0, -1);
    check(valid == 1 && len == 62, "R7 broadcast", int'(len), 62);
  endtask

  task automatic t_mid();
    build(64, 0, 11);
    send(64, 15, 0, 40);
    check(valid == 0, "R9 mid-frame rearm ignored", valid, 0);
    build(68, 0, 12);
    send(68, 15, 0, -1);
    check(valid == 1 && len == 64, "R9 next frame", int'(len), 64);
    do_rearm();
  endtask

  task automatic t_sfd();
    build(72, 0, 13);
    send(72, 1, 1, -1);
    check(valid == 1 && len == 68, "R10 short preamble", int'(len), 68);
    cmp_buf(68, "R10 alignment");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_crc();
    t_len();
    t_addr();
    t_mid();
    t_sfd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule